// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps one record for every destination register that the rename stage remaps. A record carries the instruction's sequence number, the architectural register, the physical register just allocated to it, and the physical register that the architectural register mapped to before. Records enter at the young end of a circular store. The rename map, the free list and the scoreboard stay outside the block. The block only streams operations to them.

Two walks drain the store from opposite ends. A squash carries a sequence number. Starting at the young end, each record younger than that number is undone. The map is told to point the architectural register back at its previous physical register, the new physical register goes back to the free list, and a register above the integer-plus-floating-point range also gets its scoreboard ready bit set. A commit carries a done sequence number. Starting at the old end, each record at or below that number is retired, and its previous physical register is returned to the free list. Each walk handles one record per cycle, and `busy` stays high until the walk ends.

Top module: `rename_history_buf`

## Requirements
- R1: After reset the store is empty, `busy` is low, and `restore_valid`, `free_valid`, `sb_set_valid` and `alloc_error` are all low.
- R2: An accepted `alloc_valid` appends a record at the young end. When the store already holds DEPTH records (16 by default), `alloc_error` is high in that same cycle and nothing is stored, even if a retire is removing a record in that cycle.
- R3: An allocation in a cycle that carries `squash_valid`, or during a rollback walk, is refused: `alloc_error` goes high and nothing is stored.
- R4: From the cycle after `squash_valid`, one record per cycle is undone, youngest first, for as long as the youngest record's sequence number is unsigned-greater than the squash number. Each undo shows `restore_valid` with the record's architectural register and previous physical register, and in the same cycle `free_valid` with its new physical register. Records at or below the squash number remain stored.
- R5: During an undo, `sb_set_valid` is high with `sb_set_preg` equal to the new physical register exactly when that register index is at or above PHYS_LIMIT (96 by default). `sb_set_valid` is never high outside an undo.
- R6: From the cycle after an accepted `commit_valid`, one record per cycle is retired, oldest first, while the oldest record's sequence number is at or below the done number. Each retire shows `free_valid` with the record's previous physical register, and `restore_valid` stays low.
- R7: A commit that arrives while the store is empty, or while the oldest record is already above the done number, is ignored. `busy` stays low and no output strobes.
- R8: A commit is ignored if it arrives in a cycle that carries `squash_valid`, or at any time during a rollback walk. No record is retired because of it.
- R9: `busy` is high from the cycle after an accepted squash or commit until the walk ends. The output strobes appear only while `busy` is high.
- R10: A squash that arrives during a retire walk stops that walk. Rollback starts on the next cycle, and older records that the commit had not yet reached remain stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Append a record |
| alloc_seq | input | SEQ_W | Sequence number of the renamed instruction |
| alloc_areg | input | AREG_W | Architectural destination register |
| alloc_new_preg | input | PREG_W | Physical register just allocated |
| alloc_prev_preg | input | PREG_W | Physical register previously mapped |
| alloc_error | output | 1 | Allocation refused (store full or rollback active) |
| squash_valid | input | 1 | Start a rollback |
| squash_seq | input | SEQ_W | Records above this number are undone |
| commit_valid | input | 1 | Start a retire walk |
| commit_seq | input | SEQ_W | Records at or below this number retire |
| busy | output | 1 | A walk is in progress |
| restore_valid | output | 1 | Map restore strobe |
| restore_areg | output | AREG_W | Architectural register to restore |
| restore_preg | output | PREG_W | Physical register to map it back to |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register being returned |
| sb_set_valid | output | 1 | Scoreboard ready-set strobe |
| sb_set_preg | output | PREG_W | Register to mark ready |

## Verification
The assertions assume that sequence numbers in the store rise from the old end to the young end without wrapping. They also assume that, after a squash, new allocations carry numbers above the squash number. The stimulus meets both conditions by drawing every allocation from one counter that only grows. Squash and commit numbers are picked from values near the sequence numbers currently stored. The bench waits for `busy` to fall before it issues the next operation, except in the directed cases that deliberately overlap a squash with a commit or an allocation.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE     = 2'd0,
    WALK_ROLLBACK = 2'd1,
    WALK_RETIRE   = 2'd2
  } walk_mode_e;

  // unsigned ordering of sequence numbers: a is younger than b
  function automatic logic seq_after(input logic [63:0] a, input logic [63:0] b);
    return a > b;
  endfunction

  // registers beyond the int+fp range need a scoreboard ready-set on undo
  function automatic logic needs_ready_set(input logic [31:0] preg, input logic [31:0] limit);
    return preg >= limit;
  endfunction

  function automatic logic alloc_refused(input logic req, input logic full,
                                         input logic rolling, input logic squash_now);
    return req && (full || rolling || squash_now);
  endfunction

endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new,
  input  logic [PREG_W-1:0] push_prev,
  input  logic              pop_young,
  input  logic              pop_old,
  output logic [SEQ_W-1:0]  young_seq,
  output logic [AREG_W-1:0] young_areg,
  output logic [PREG_W-1:0] young_new,
  output logic [PREG_W-1:0] young_prev,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PREG_W-1:0] old_prev,
  output logic              empty,
  output logic              full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [AREG_W-1:0] areg;
    logic [PREG_W-1:0] newp;
    logic [PREG_W-1:0] prevp;
  } rec_t;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] count_q;
  rec_t             wr_rec;
  rec_t             slot_rd [DEPTH];

  assign wr_rec = {push_seq, push_areg, push_new, push_prev};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rec_t rec_q;
    logic hit;
    assign hit = push && (tail_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (hit) rec_q <= wr_rec;
    end
    assign slot_rd[g] = rec_q;
  end

  assign young_idx  = ptr_prev(tail_q);
  assign young_seq  = slot_rd[young_idx].seq;
  assign young_areg = slot_rd[young_idx].areg;
  assign young_new  = slot_rd[young_idx].newp;
  assign young_prev = slot_rd[young_idx].prevp;
  assign old_seq    = slot_rd[head_q].seq;
  assign old_prev   = slot_rd[head_q].prevp;

  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push)      tail_q <= ptr_next(tail_q);
      if (pop_young) tail_q <= ptr_prev(tail_q);
      if (pop_old)   head_q <= ptr_next(head_q);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop_young) - CNT_W'(pop_old);
    end
  end

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R2
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young || pop_old) |-> !empty);

  // R3
  push_vs_undo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop_young));

endmodule

// File: rtl/rhb_walker.sv
module rhb_walker
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             empty,
  input  logic [SEQ_W-1:0] young_seq,
  input  logic [SEQ_W-1:0] old_seq,
  output logic             roll_step,
  output logic             retire_step,
  output logic             rolling,
  output logic             busy
);

  walk_mode_e       mode_q;
  logic [SEQ_W-1:0] squash_q, done_q;
  logic             commit_take;

  assign rolling = (mode_q == WALK_ROLLBACK);
  assign busy    = (mode_q != WALK_IDLE);

  assign roll_step   = rolling && !empty && seq_after(64'(young_seq), 64'(squash_q));
  assign retire_step = (mode_q == WALK_RETIRE) && !empty &&
                       !seq_after(64'(old_seq), 64'(done_q));

  // a commit is dropped on a squash cycle, during rollback, or when nothing qualifies
  assign commit_take = commit_valid && !squash_valid && !rolling && !empty &&
                       !seq_after(64'(old_seq), 64'(commit_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= WALK_IDLE;
      squash_q <= '0;
      done_q   <= '0;
    end else if (squash_valid) begin
      mode_q   <= WALK_ROLLBACK;
      squash_q <= squash_seq;
    end else if (rolling) begin
      if (!roll_step) mode_q <= WALK_IDLE;
    end else if (commit_take) begin
      mode_q <= WALK_RETIRE;
      done_q <= commit_seq;
    end else if ((mode_q == WALK_RETIRE) && !retire_step) begin
      mode_q <= WALK_IDLE;
    end
  end

  // R9
  squash_opens_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> busy);

  // R8
  no_retire_after_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !retire_step);

  // R7
  empty_commit_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && empty && !busy && !squash_valid) |=> !busy);

  // R10
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(roll_step && retire_step));

endmodule

// File: rtl/rhb_emit.sv
module rhb_emit
  import rhb_pkg::*;
#(
  parameter int AREG_W     = 5,
  parameter int PREG_W     = 7,
  parameter int PHYS_LIMIT = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll_step,
  input  logic              retire_step,
  input  logic [AREG_W-1:0] young_areg,
  input  logic [PREG_W-1:0] young_new,
  input  logic [PREG_W-1:0] young_prev,
  input  logic [PREG_W-1:0] old_prev,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              sb_set_valid,
  output logic [PREG_W-1:0] sb_set_preg
);

  assign restore_valid = roll_step;
  assign restore_areg  = young_areg;
  assign restore_preg  = young_prev;

  // one free port serves both walks; undo returns the new reg, retire the old one
  assign free_valid = roll_step || retire_step;
  assign free_preg  = roll_step ? young_new : old_prev;

  assign sb_set_valid = roll_step && needs_ready_set(32'(young_new), 32'(PHYS_LIMIT));
  assign sb_set_preg  = young_new;

  // R5
  ready_set_with_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_set_valid |-> (free_valid && free_preg == sb_set_preg));

  // R4
  restore_pairs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> free_valid);

endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf
  import rhb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SEQ_W      = 16,
  parameter int AREG_W     = 5,
  parameter int PREG_W     = 7,
  parameter int PHYS_LIMIT = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic [PREG_W-1:0] alloc_new_preg,
  input  logic [PREG_W-1:0] alloc_prev_preg,
  output logic              alloc_error,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              busy,
  output logic              restore_valid,
  output logic [AREG_W-1:0] restore_areg,
  output logic [PREG_W-1:0] restore_preg,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              sb_set_valid,
  output logic [PREG_W-1:0] sb_set_preg
);

  logic              push, empty, full, rolling;
  logic              roll_step, retire_step;
  logic [SEQ_W-1:0]  young_seq, old_seq;
  logic [AREG_W-1:0] young_areg;
  logic [PREG_W-1:0] young_new, young_prev, old_prev;

  assign alloc_error = alloc_refused(alloc_valid, full, rolling, squash_valid);
  assign push        = alloc_valid && !alloc_error;

  rhb_store #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W),
    .AREG_W(AREG_W),
    .PREG_W(PREG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_seq  (alloc_seq),
    .push_areg (alloc_areg),
    .push_new  (alloc_new_preg),
    .push_prev (alloc_prev_preg),
    .pop_young (roll_step),
    .pop_old   (retire_step),
    .young_seq (young_seq),
    .young_areg(young_areg),
    .young_new (young_new),
    .young_prev(young_prev),
    .old_seq   (old_seq),
    .old_prev  (old_prev),
    .empty     (empty),
    .full      (full)
  );

  rhb_walker #(
    .SEQ_W(SEQ_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .squash_valid(squash_valid),
    .squash_seq  (squash_seq),
    .commit_valid(commit_valid),
    .commit_seq  (commit_seq),
    .empty       (empty),
    .young_seq   (young_seq),
    .old_seq     (old_seq),
    .roll_step   (roll_step),
    .retire_step (retire_step),
    .rolling     (rolling),
    .busy        (busy)
  );

  rhb_emit #(
    .AREG_W    (AREG_W),
    .PREG_W    (PREG_W),
    .PHYS_LIMIT(PHYS_LIMIT)
  ) u_emit (
    .clk          (clk),
    .rst_n        (rst_n),
    .roll_step    (roll_step),
    .retire_step  (retire_step),
    .young_areg   (young_areg),
    .young_new    (young_new),
    .young_prev   (young_prev),
    .old_prev     (old_prev),
    .restore_valid(restore_valid),
    .restore_areg (restore_areg),
    .restore_preg (restore_preg),
    .free_valid   (free_valid),
    .free_preg    (free_preg),
    .sb_set_valid (sb_set_valid),
    .sb_set_preg  (sb_set_preg)
  );

  // R9
  strobes_need_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid || restore_valid || sb_set_valid) |-> busy);

  // R3
  no_alloc_in_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && restore_valid) |-> alloc_error);

endmodule

// File: tb/rename_history_buf_tb.sv
`timescale 1ns/1ps
module rename_history_buf_tb;

  localparam int DEPTH = 16, SEQ_W = 16, AREG_W = 5, PREG_W = 7, LIMIT = 96;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic [SEQ_W-1:0]  alloc_seq = '0;
  logic [AREG_W-1:0] alloc_areg = '0;
  logic [PREG_W-1:0] alloc_new_preg = '0, alloc_prev_preg = '0;
  logic              alloc_error;
  logic              squash_valid = 1'b0;
  logic [SEQ_W-1:0]  squash_seq = '0;
  logic              commit_valid = 1'b0;
  logic [SEQ_W-1:0]  commit_seq = '0;
  logic              busy, restore_valid, free_valid, sb_set_valid;
  logic [AREG_W-1:0] restore_areg;
  logic [PREG_W-1:0] restore_preg, free_preg, sb_set_preg;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
                       .PREG_W(PREG_W), .PHYS_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_areg(alloc_areg),
    .alloc_new_preg(alloc_new_preg), .alloc_prev_preg(alloc_prev_preg),
    .alloc_error(alloc_error),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .busy(busy),
    .restore_valid(restore_valid), .restore_areg(restore_areg), .restore_preg(restore_preg),
    .free_valid(free_valid), .free_preg(free_preg),
    .sb_set_valid(sb_set_valid), .sb_set_preg(sb_set_preg)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int q_seq[$], q_areg[$], q_new[$], q_prev[$];
  int cur_sq = 0, cur_done = -1, next_seq = 1;
  bit mon_on = 1'b0;

  function automatic void check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic bit wants_ready(int p);
    return p >= LIMIT;
  endfunction

  // reference model follows every strobe
  always @(negedge clk) begin
    if (mon_on) begin
      if ((restore_valid || free_valid || sb_set_valid) && !busy)
        check(1'b0, "R9 strobe while idle", 1, 0);
      if (restore_valid) begin
        if (q_seq.size() == 0) check(1'b0, "R4 undo with empty model", 1, 0);
        else begin
          check(q_seq[$] > cur_sq, "R4 undone seq above squash", q_seq[$], cur_sq);
          check(int'(restore_areg) == q_areg[$], "R4 restore areg", int'(restore_areg), q_areg[$]);
          check(int'(restore_preg) == q_prev[$], "R4 restore preg", int'(restore_preg), q_prev[$]);
          check(free_valid && int'(free_preg) == q_new[$], "R4 freed new preg",
                int'(free_preg), q_new[$]);
          check(sb_set_valid == wants_ready(q_new[$]), "R5 ready-set strobe",
                int'(sb_set_valid), int'(wants_ready(q_new[$])));
          if (sb_set_valid)
            check(int'(sb_set_preg) == q_new[$], "R5 ready-set preg", int'(sb_set_preg), q_new[$]);
          void'(q_seq.pop_back()); void'(q_areg.pop_back());
          void'(q_new.pop_back()); void'(q_prev.pop_back());
        end
      end else if (free_valid) begin
        check(!sb_set_valid, "R5 no ready-set on retire", int'(sb_set_valid), 0);
        if (q_seq.size() == 0) check(1'b0, "R6 retire with empty model", 1, 0);
        else begin
          check(q_seq[0] <= cur_done, "R6 retired seq within done", q_seq[0], cur_done);
          check(int'(free_preg) == q_prev[0], "R6 freed prev preg", int'(free_preg), q_prev[0]);
          void'(q_seq.pop_front()); void'(q_areg.pop_front());
          void'(q_new.pop_front()); void'(q_prev.pop_front());
        end
      end else if (sb_set_valid) begin
        check(1'b0, "R5 ready-set without undo", 1, 0);
      end
    end
  end

  task automatic alloc(int s, int a, int n, int p);
    bit exp_err;
    @(negedge clk);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(s); alloc_areg = AREG_W'(a);
    alloc_new_preg = PREG_W'(n); alloc_prev_preg = PREG_W'(p);
    #1;
    exp_err = (q_seq.size() == DEPTH);
    check(alloc_error == exp_err, "R2 alloc_error", int'(alloc_error), int'(exp_err));
    if (!exp_err) begin
      q_seq.push_back(s); q_areg.push_back(a); q_new.push_back(n); q_prev.push_back(p);
    end
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (1) begin
      @(negedge clk);
      if (!busy) break;
      guard++;
      if (guard > 64) begin check(1'b0, "R9 walk never ended", 1, 0); break; end
    end
  endtask

  task automatic squash(int sq, bit with_commit, bit with_alloc);
    @(negedge clk);
    squash_valid = 1'b1; squash_seq = SEQ_W'(sq); cur_sq = sq;
    if (with_commit) begin commit_valid = 1'b1; commit_seq = '1; end
    if (with_alloc) begin alloc_valid = 1'b1; alloc_seq = SEQ_W'(next_seq); end
    #1;
    if (with_alloc) check(alloc_error == 1'b1, "R3 alloc refused on squash cycle", int'(alloc_error), 1);
    @(posedge clk); #1;
    squash_valid = 1'b0; commit_valid = 1'b0; alloc_valid = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after squash", int'(busy), 1);
    if (busy) wait_idle();
    check(q_seq.size() == 0 || q_seq[$] <= sq, "R4 rollback stop point",
          (q_seq.size() == 0) ? -1 : q_seq[$], sq);
  endtask

  task automatic commit(int done);
    bit ign;
    @(negedge clk);
    ign = (q_seq.size() == 0) || (q_seq[0] > done);
    if (!ign) cur_done = done;
    commit_valid = 1'b1; commit_seq = SEQ_W'(done);
    @(posedge clk); #1 commit_valid = 1'b0;
    @(negedge clk);
    if (ign) check(busy == 1'b0, "R7 ignored commit keeps busy low", int'(busy), 0);
    else     check(busy == 1'b1, "R9 busy after commit", int'(busy), 1);
    if (busy) wait_idle();
    check(q_seq.size() == 0 || q_seq[0] > done, "R6 retire stop point",
          (q_seq.size() == 0) ? -1 : q_seq[0], done);
  endtask

  initial begin : main
    int exp_left;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(!restore_valid && !free_valid && !sb_set_valid, "R1 strobes after reset",
          int'(restore_valid | free_valid | sb_set_valid), 0);
    check(alloc_error == 1'b0, "R1 alloc_error after reset", int'(alloc_error), 0);
    mon_on = 1'b1;

    commit(10);                                   // R7 empty store
    alloc(1, 3, 100, 4);  alloc(2, 7, 20, 5);  alloc(3, 9, 96, 6);
    alloc(4, 1, 95, 7);   alloc(5, 2, 127, 8); alloc(6, 3, 30, 9);
    commit(0);                                    // R7 oldest already above done
    squash(3, 1'b1, 1'b1);                        // R4 R5 R8 R3: undo 6,5,4
    check(q_seq.size() == 3, "R8 commit on squash cycle retired nothing", q_seq.size(), 3);

    // R10: squash lands while a retire walk runs
    alloc(10, 4, 110, 11); alloc(11, 5, 12, 13); alloc(12, 6, 99, 14);
    @(negedge clk);
    cur_done = 11; commit_valid = 1'b1; commit_seq = SEQ_W'(11);
    @(posedge clk); #1 commit_valid = 1'b0;
    @(negedge clk);
    squash_valid = 1'b1; squash_seq = SEQ_W'(10); cur_sq = 10;
    @(posedge clk); #1 squash_valid = 1'b0;
    wait_idle();
    check(q_seq.size() == 3, "R10 abort left older records", q_seq.size(), 3);
    check(q_seq.size() > 0 && q_seq[0] == 2, "R10 oldest after abort",
          (q_seq.size() > 0) ? q_seq[0] : -1, 2);

    // R8 R3: commit and alloc in the middle of a rollback
    alloc(20, 1, 97, 2); alloc(21, 2, 3, 4); alloc(22, 3, 5, 6); alloc(23, 4, 120, 7);
    @(negedge clk);
    squash_valid = 1'b1; squash_seq = SEQ_W'(10); cur_sq = 10;
    @(posedge clk); #1 squash_valid = 1'b0;
    @(negedge clk);
    commit_valid = 1'b1; commit_seq = '1;
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(30);
    #1 check(alloc_error == 1'b1, "R3 alloc refused during rollback", int'(alloc_error), 1);
    @(posedge clk); #1 begin commit_valid = 1'b0; alloc_valid = 1'b0; end
    wait_idle();
    check(q_seq.size() == 3, "R8 commit during rollback ignored", q_seq.size(), 3);

    commit(10);                                   // R6 drain all
    check(q_seq.size() == 0, "R6 drained", q_seq.size(), 0);

    // R2 full store
    for (int i = 0; i < DEPTH + 1; i++) alloc(40 + i, i % 32, (i * 9) % 128, i);
    check(q_seq.size() == DEPTH, "R2 store holds DEPTH", q_seq.size(), DEPTH);
    commit(43);
    squash(0, 1'b0, 1'b0);                        // R4 undo everything
    check(q_seq.size() == 0, "R4 full undo empties store", q_seq.size(), 0);
    next_seq = 100;

    for (int i = 0; i < 300; i++) begin
      int r, idx, v;
      r = int'($urandom % 10);
      if (r < 6) begin
        alloc(next_seq, int'($urandom % 32), int'($urandom % 128), int'($urandom % 128));
        next_seq += 1 + int'($urandom % 3);
      end else if (r < 8) begin
        if (q_seq.size() > 0) begin
          idx = int'($urandom % q_seq.size());
          v = q_seq[idx] - int'($urandom % 2);
        end else v = next_seq;
        commit(v);
      end else begin
        if (q_seq.size() > 0) begin
          idx = int'($urandom % q_seq.size());
          v = q_seq[idx] - int'($urandom % 2);
        end else v = next_seq - 1;
        exp_left = 0;
        foreach (q_seq[k]) if (q_seq[k] <= v) exp_left++;
        squash(v, ($urandom % 4) == 0, ($urandom % 4) == 0);
        check(q_seq.size() == exp_left, "R4 records at or below squash kept", q_seq.size(), exp_left);
      end
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule